// File: doc/BRIEF.md
# Two-Stage Stream Width Converter

This block sits between a 64-bit memory-side word stream and the first layer of a streaming image pipeline. It turns incoming 64-bit words into pixels, either 24-bit colour pixels (three 8-bit channels) or 8-bit grayscale pixels. Both sides use valid/ready handshaking, and back-pressure on either side never drops or repeats data.

Each stage of the converter can only scale by a whole-number ratio, and 24 does not divide 64. The colour path therefore first packs three input words into a 192-bit intermediate word, which is the least common multiple of the two widths. A second stage then unpacks that word into eight pixels. In grayscale mode the packing stage is skipped, and each 64-bit word is unpacked directly into eight pixels.

A pulse on `start` captures the mode and a repetition count. The block then processes that many 32x32-pixel images, one after another, and pulses `done` once the final pixel has been taken downstream.

Top module: `pix_width_conv`

## Requirements
- R1: While reset is applied and right after it, `out_valid`, `in_ready` and `done` are low.
- R2: In colour mode (`gray_mode`=0 at start), three consecutively accepted words w0, w1, w2 form the value {w2,w1,w0}. Eight pixels follow on `out_data[23:0]`, and pixel j is bits [24j+23:24j], for j = 0 up to 7.
- R3: In grayscale mode (`gray_mode`=1 at start), each accepted word gives eight pixels. Pixel j is word bits [8j+7:8j], for j = 0 up to 7. Each pixel appears on `out_data[7:0]`, and `out_data[23:8]` is zero.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value. Every pixel is delivered exactly once, in order.
- R5: A job accepts exactly reps x 384 words in colour mode and reps x 128 words in grayscale mode. After that, `in_ready` stays low.
- R6: `done` is high for exactly one cycle. That cycle directly follows the handshake of the last pixel of the final image (1024 pixels per image). At that point no pixel is pending.
- R7: `start` clears all counters and any partly converted data. `out_valid` is low in the next cycle. Mode and repetition count are captured at `start`, and changes on those inputs during a job are ignored.
- R8: A `start` with `reps`=0 accepts no word and pulses `done` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job; captures mode and count |
| gray_mode | input | 1 | 1 selects 8-bit grayscale output, 0 selects 24-bit colour |
| reps | input | 16 | Number of images in the job |
| in_data | input | 64 | Input word |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take the input word |
| out_data | output | 24 | Output pixel, grayscale in the low 8 bits |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream takes the pixel |
| done | output | 1 | One-cycle pulse when the job has finished |

## Verification
The embedded properties check on every cycle that a stalled pixel is held and not lost (R4). They also check that `done` is a single pulse arriving with the pipeline drained and input closed (R6), and that `start` flushes any pending pixel (R7). Only the bench's scenarios can show that pixel contents and their order match the packing rule in both modes (R2, R3). The same holds for the exact word counts per image (R5), the timing of `done` against the last handshake, the reps=0 case, and a restart in the middle of a job that ignores mode toggling during the job.

// File: rtl/pix_width_conv.sv
module pix_width_conv #(
  parameter int IN_W    = 64,
  parameter int RGB_W   = 24,
  parameter int GRAY_W  = 8,
  parameter int IMG_PIX = 1024,
  parameter int REP_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             gray_mode,
  input  logic [REP_W-1:0] reps,
  input  logic [IN_W-1:0]  in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [RGB_W-1:0] out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             done
);
  function automatic int gcd(int a, int b);
    int x = a, y = b, t;
    while (y != 0) begin t = x % y; x = y; y = t; end
    return x;
  endfunction

  localparam int MID_W    = IN_W / gcd(IN_W, RGB_W) * RGB_W;
  localparam int UP_N     = MID_W / IN_W;
  localparam int DN_RGB   = MID_W / RGB_W;
  localparam int DN_GRAY  = IN_W / GRAY_W;
  localparam int WPI_RGB  = IMG_PIX * RGB_W / IN_W;
  localparam int WPI_GRAY = IMG_PIX * GRAY_W / IN_W;
  localparam int AW  = $clog2(UP_N + 1);
  localparam int DW  = $clog2(DN_RGB > DN_GRAY ? DN_RGB : DN_GRAY);
  localparam int WW  = $clog2(WPI_RGB > WPI_GRAY ? WPI_RGB : WPI_GRAY);
  localparam int PW  = $clog2(IMG_PIX);
  localparam logic [AW-1:0] ACC_FULL = AW'(UP_N);
  localparam logic [DW-1:0] DL_RGB   = DW'(DN_RGB - 1);
  localparam logic [DW-1:0] DL_GRAY  = DW'(DN_GRAY - 1);
  localparam logic [WW-1:0] WL_RGB   = WW'(WPI_RGB - 1);
  localparam logic [WW-1:0] WL_GRAY  = WW'(WPI_GRAY - 1);
  localparam logic [PW-1:0] PL       = PW'(IMG_PIX - 1);

  logic             gray_q;
  logic [REP_W-1:0] reps_q, in_rep, out_rep;
  logic [WW-1:0]    in_wcnt;
  logic [PW-1:0]    out_pcnt;
  logic [MID_W-1:0] acc, dn_q;
  logic [AW-1:0]    acc_n;
  logic [DW-1:0]    dn_idx;
  logic             dn_valid, done_q;

  wire in_more  = in_rep != reps_q;
  wire dn_last  = dn_idx == (gray_q ? DL_GRAY : DL_RGB);
  wire dn_take  = dn_valid && out_ready;
  wire dn_free  = !dn_valid || (dn_take && dn_last);
  wire acc_full = acc_n == ACC_FULL;
  wire xfer     = !gray_q && acc_full && dn_free;
  wire in_fire  = in_valid && in_ready;
  wire w_last   = in_wcnt == (gray_q ? WL_GRAY : WL_RGB);
  wire p_last   = out_pcnt == PL;

  assign in_ready  = in_more && (gray_q ? dn_free : (!acc_full || xfer));
  assign out_valid = dn_valid;
  assign done      = done_q;
  assign out_data  = gray_q ? {{(RGB_W-GRAY_W){1'b0}}, dn_q[dn_idx*GRAY_W +: GRAY_W]}
                            : dn_q[dn_idx*RGB_W +: RGB_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gray_q <= 1'b0; reps_q <= '0; in_rep <= '0; out_rep <= '0;
      in_wcnt <= '0; out_pcnt <= '0; done_q <= 1'b0;
    end else if (start) begin
      gray_q <= gray_mode; reps_q <= reps; in_rep <= '0; out_rep <= '0;
      in_wcnt <= '0; out_pcnt <= '0; done_q <= reps == '0;
    end else begin
      done_q <= 1'b0;
      if (in_fire) begin
        in_wcnt <= w_last ? '0 : in_wcnt + 1'b1;
        if (w_last) in_rep <= in_rep + 1'b1;
      end
      if (dn_take) begin
        out_pcnt <= p_last ? '0 : out_pcnt + 1'b1;
        if (p_last) begin
          out_rep <= out_rep + 1'b1;
          if (out_rep == reps_q - 1'b1) done_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      acc_n <= '0;
    end else if (xfer) begin
      acc_n <= in_fire ? AW'(1) : '0;
    end else if (in_fire && !gray_q) begin
      acc_n <= acc_n + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire && !gray_q) acc[(xfer ? '0 : acc_n)*IN_W +: IN_W] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      dn_valid <= 1'b0; dn_idx <= '0;
    end else if (gray_q && in_fire) begin
      dn_q <= {{(MID_W-IN_W){1'b0}}, in_data}; dn_valid <= 1'b1; dn_idx <= '0;
    end else if (xfer) begin
      dn_q <= acc; dn_valid <= 1'b1; dn_idx <= '0;
    end else if (dn_take) begin
      if (dn_last) dn_valid <= 1'b0;
      else dn_idx <= dn_idx + 1'b1;
    end
  end

  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !start |=> out_valid && $stable(out_data));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);
  a_r6_drained: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid && !in_ready);
  a_r7_start_flush: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !out_valid);
endmodule

// File: tb/test_pix_width_conv.sv
module test_pix_width_conv;
  logic clk = 0, rst_n = 0, start = 0, gray_mode = 0, in_valid = 0, out_ready = 0;
  logic [15:0] reps = 0;
  logic [63:0] in_data = 0;
  logic in_ready, out_valid, done;
  logic [23:0] out_data;
  int errors = 0, checks = 0, cycles = 0;

  always #2 clk = ~clk;

  pix_width_conv i_pix_width_conv (.clk, .rst_n, .start, .gray_mode, .reps,
    .in_data, .in_valid, .in_ready, .out_data, .out_valid, .out_ready, .done);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] word(int n);
    logic [31:0] u = n;
    return {u ^ 32'h5A5A_0F0F, u * 32'h9E37_79B9 + 32'h1234};
  endfunction

  function automatic logic [23:0] exp_pix(bit g, int p);
    logic [63:0] w;
    logic [191:0] mid;
    if (g) begin
      w = word(p / 8);
      return {16'h0, w[8*(p%8) +: 8]};
    end
    mid = {word(3*(p/8)+2), word(3*(p/8)+1), word(3*(p/8))};
    return mid[24*(p%8) +: 24];
  endfunction

  task automatic pulse_start(input bit g, input int r);
    @(negedge clk); gray_mode = g; reps = 16'(r); start = 1; in_valid = 0;
    @(negedge clk); start = 0; gray_mode = ~g;
  endtask

  task automatic run_job(input bit g, input int r, input int gap, input int stall, input string tag);
    int nw = r * (g ? 128 : 384), np = r * 1024;
    int wi = 0, pi = 0, cyc = 0, last_fire = -10;
    bit seen = 0, hold = 0, perr = 0;
    logic [23:0] held = 0, e;
    pulse_start(g, r);
    chk(!out_valid, {"R7 ", tag, " flushed after start"}, 64'(out_valid), 0);
    while (!seen && cyc < 8*np + 200) begin
      in_valid = (wi < nw) && (gap == 0 || cyc % 3 != 0);
      in_data = word(wi);
      out_ready = (stall == 0) || (cyc % 5 < 2);
      #1;
      if (hold) chk(out_valid && out_data == held, {"R4 ", tag, " stalled pixel held"}, 64'(out_data), 64'(held));
      if (done) begin
        seen = 1;
        chk(pi == np && cyc == last_fire + 1, {"R6 ", tag, " done timing"}, 64'(pi), 64'(np));
      end
      if (in_valid && in_ready) wi++;
      hold = 0;
      if (out_valid && out_ready) begin
        e = exp_pix(g, pi);
        if (out_data !== e && !perr) begin
          perr = 1;
          chk(0, {g ? "R3 " : "R2 ", tag, " pixel value"}, 64'(out_data), 64'(e));
        end
        pi++; last_fire = cyc;
      end else if (out_valid) begin
        hold = 1; held = out_data;
      end
      @(negedge clk); cyc++;
    end
    in_valid = 0;
    if (np > 0) chk(!perr, {g ? "R3 " : "R2 ", tag, " all pixels in order"}, 64'(pi), 64'(np));
    chk(seen, {"R6 ", tag, " done seen"}, 64'(seen), 1);
    chk(wi == nw, {"R5 ", tag, " words accepted"}, 64'(wi), 64'(nw));
    in_valid = 1; #1;
    chk(!done, {"R6 ", tag, " done one cycle"}, 64'(done), 0);
    for (int k = 0; k < 4; k++) begin
      #1; chk(!in_ready, {"R5 ", tag, " no input after job"}, 64'(in_ready), 0);
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  task automatic t_reset;
    #1;
    chk(!out_valid && !in_ready && !done, "R1 outputs low in reset", {in_ready, out_valid, done}, 0);
    @(negedge clk); rst_n = 1; #1;
    chk(!out_valid && !in_ready && !done, "R1 outputs low after reset", {in_ready, out_valid, done}, 0);
  endtask

  task automatic t_zero_reps;
    pulse_start(0, 0);
    in_valid = 1; #1;
    chk(done && !in_ready, "R8 done with zero reps", {done, in_ready}, 2'b10);
    @(negedge clk); #1;
    chk(!done && !in_ready && !out_valid, "R8 idle after zero-rep done", {done, in_ready, out_valid}, 0);
    in_valid = 0;
  endtask

  task automatic t_restart;
    pulse_start(0, 2);
    out_ready = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); in_valid = 1; in_data = 64'hDEAD_0000 + 64'(k);
      if (k == 10) out_ready = 1;
    end
    in_valid = 0;
    run_job(1, 1, 0, 0, "restart into gray");
  endtask

  initial begin
    t_reset();
    run_job(0, 1, 0, 0, "rgb plain");
    run_job(0, 2, 1, 1, "rgb gaps stalls");
    run_job(1, 1, 0, 0, "gray plain");
    run_job(1, 2, 1, 1, "gray gaps stalls");
    t_zero_reps();
    t_restart();
    run_job(0, 1, 0, 1, "rgb after gray");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule